// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a load/store processor core. Instructions name 32 logical registers with 5-bit numbers. Eight of them are global and the same in every context. The other 24 form a window into a circular stack of physical register sets. Each set holds 16 registers. A window is built from the set's 8 ins and 8 locals plus 8 outs. The outs are the ins of the neighbouring set, so a caller can hand arguments to a callee without copying them.

A current-window pointer picks the active window. A save command moves the pointer one set down and a restore command moves it one set up, wrapping around the stack. A per-set invalid mask guards the stack edges. A rotation whose target set is masked does not happen, and the block raises a one-cycle overflow flag (save) or underflow flag (restore) for the trap logic. Two read ports are combinational and the single write port is clocked.

Top module: `win_regfile`

## Requirements
- R1: Logical registers 0..7 are globals: a value written to global k is read back as logical register k in every window.
- R2: Global 0 always reads as zero; a write to logical register 0 changes nothing.
- R3: In window w, logical 16..23 are the locals of set w and logical 24..31 are the ins of set w. Locals and ins of different sets are separate storage.
- R4: Logical 8..15 (outs) of window w are the same storage as logical 24..31 (ins) of window (w-1) mod NWIN, matched in order (8+k with 24+k).
- R5: A save whose target (w-1) mod NWIN is not masked sets cwp_o to that target at the next clock edge.
- R6: A restore whose target (w+1) mod NWIN is not masked sets cwp_o to that target at the next clock edge.
- R7: A save whose target is masked leaves cwp_o unchanged, and ovf_o is 1 for exactly the following cycle.
- R8: A restore whose target is masked leaves cwp_o unchanged, and unf_o is 1 for exactly the following cycle.
- R9: Read ports are combinational and the write port takes effect at the clock edge: a read of the register being written in the same cycle returns the old value.
- R10: After reset cwp_o is 0, both flags are 0, and the invalid mask has only bit NWIN-1 set (the save target of window 0).
- R11: With wim_we_i high, wim_i is loaded into the invalid mask at the clock edge. A rotation in that same cycle is checked against the old mask.
- R12: When save_i and restore_i are both high, the save is carried out (or flagged) and the restore is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| save_i | input | 1 | Rotate window pointer down |
| restore_i | input | 1 | Rotate window pointer up |
| wim_we_i | input | 1 | Load the invalid mask |
| wim_i | input | NWIN | New invalid mask, bit per set |
| ra_addr_i | input | 5 | Read port A logical register |
| ra_data_o | output | DW | Read port A data |
| rb_addr_i | input | 5 | Read port B logical register |
| rb_data_o | output | DW | Read port B data |
| we_i | input | 1 | Write enable |
| wa_addr_i | input | 5 | Write logical register |
| wd_i | input | DW | Write data |
| cwp_o | output | CW | Current window pointer |
| ovf_o | output | 1 | Save blocked by mask (one-cycle pulse) |
| unf_o | output | 1 | Restore blocked by mask (one-cycle pulse) |

## Verification
The bench uses four windows and clears the mask. It writes a distinct arithmetic pattern into the locals and ins of every set and into the globals. It then reads all 32 logical registers of every window on both ports. This tells a wrong group decode apart from a wrong neighbour in the out/in overlap, and a private local apart from a shared one. Rotation is driven through both wrap points, against the reset mask and against reloaded masks. Save and restore are also raised together, once with the save allowed and once with it blocked. These cases separate the two flags and the save priority, and show which mask a same-cycle load leaves in force. Same-cycle write/read and writes to global 0 are probed directly at the ports.

// File: rtl/win_rf_pkg.sv
package win_rf_pkg;
  localparam int GRP_SIZE = 8;
  localparam int SET_SIZE = 16;
  localparam int LREG_W   = 5;

  typedef enum logic [1:0] {
    GRP_GLB = 2'b00,
    GRP_OUT = 2'b01,
    GRP_LOC = 2'b10,
    GRP_IN  = 2'b11
  } reg_grp_e;
endpackage

// File: rtl/win_addr_map.sv
module win_addr_map
  import win_rf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN),
  parameter int PW   = 8
) (
  input  logic [CW-1:0]     cwp_i,
  input  logic [LREG_W-1:0] lreg_i,
  output logic [PW-1:0]     phys_o
);
  reg_grp_e grp;
  int       set_idx;
  int       base;

  assign grp = reg_grp_e'(lreg_i[4:3]);

  always_comb begin
    set_idx = int'(cwp_i);
    base    = 0;
    unique case (grp)
      GRP_GLB: base = 0;
      // outs live in the ins of the next-lower set
      GRP_OUT: begin
        set_idx = (cwp_i == '0) ? NWIN - 1 : int'(cwp_i) - 1;
        base    = GRP_SIZE + set_idx * SET_SIZE;
      end
      GRP_LOC: base = GRP_SIZE + set_idx * SET_SIZE + GRP_SIZE;
      GRP_IN:  base = GRP_SIZE + set_idx * SET_SIZE;
      default: base = 0;
    endcase
    phys_o = PW'(base + int'(lreg_i[2:0]));
  end
endmodule

// File: rtl/win_ptr_ctrl.sv
module win_ptr_ctrl #(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic            wim_we_i,
  input  logic [NWIN-1:0] wim_i,
  output logic [CW-1:0]   cwp_o,
  output logic            ovf_o,
  output logic            unf_o
);
  localparam logic [CW-1:0]   LAST_WIN  = CW'(NWIN - 1);
  localparam logic [NWIN-1:0] WIM_RESET = NWIN'(1) << (NWIN - 1);

  logic [CW-1:0]   cwp_q, save_tgt, rest_tgt;
  logic [NWIN-1:0] wim_q;
  logic            ovf_q, unf_q;
  logic            save_blk, rest_blk, do_rest;

  assign save_tgt = (cwp_q == '0) ? LAST_WIN : cwp_q - CW'(1);
  assign rest_tgt = (cwp_q == LAST_WIN) ? '0 : cwp_q + CW'(1);
  assign save_blk = wim_q[save_tgt];
  assign rest_blk = wim_q[rest_tgt];
  assign do_rest  = restore_i && !save_i;  // save wins

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      wim_q <= WIM_RESET;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (save_i && !save_blk)      cwp_q <= save_tgt;
      else if (do_rest && !rest_blk) cwp_q <= rest_tgt;
      if (wim_we_i) wim_q <= wim_i;
      ovf_q <= save_i && save_blk;
      unf_q <= do_rest && rest_blk;
    end
  end

  assign cwp_o = cwp_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  p_save_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !save_blk) |=>
      ((cwp_q + CW'(1) == $past(cwp_q)) || ($past(cwp_q) == '0 && cwp_q == LAST_WIN)));

  p_rest_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_rest && !rest_blk) |=>
      ((cwp_q == $past(cwp_q) + CW'(1)) || ($past(cwp_q) == LAST_WIN && cwp_q == '0)));

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (cwp_q == $past(cwp_q)));

  p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (cwp_q == $past(cwp_q)));

  p_flag_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));

  p_cwp_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cwp_q) < NWIN);
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DW    = 32,
  parameter int NPHYS = 136,
  parameter int PW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] ra_idx_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [PW-1:0] rb_idx_i,
  output logic [DW-1:0] rb_data_o,
  input  logic          we_i,
  input  logic [PW-1:0] wa_idx_i,
  input  logic [DW-1:0] wd_i
);
  logic [DW-1:0] mem_q [NPHYS];

  // physical 0 is global 0: never written, stays zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPHYS; i++) mem_q[i] <= '0;
    end else if (we_i && wa_idx_i != '0) begin
      mem_q[wa_idx_i] <= wd_i;
    end
  end

  assign ra_data_o = mem_q[ra_idx_i];
  assign rb_data_o = mem_q[rb_idx_i];

  p_g0_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_q[0] == '0);

  p_write_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_idx_i != '0) |=> (mem_q[$past(wa_idx_i)] == $past(wd_i)));
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import win_rf_pkg::*;
#(
  parameter int  NWIN = 8,
  parameter int  DW   = 32,
  localparam int CW   = $clog2(NWIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              save_i,
  input  logic              restore_i,
  input  logic              wim_we_i,
  input  logic [NWIN-1:0]   wim_i,
  input  logic [LREG_W-1:0] ra_addr_i,
  output logic [DW-1:0]     ra_data_o,
  input  logic [LREG_W-1:0] rb_addr_i,
  output logic [DW-1:0]     rb_data_o,
  input  logic              we_i,
  input  logic [LREG_W-1:0] wa_addr_i,
  input  logic [DW-1:0]     wd_i,
  output logic [CW-1:0]     cwp_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int NPHYS = GRP_SIZE + SET_SIZE * NWIN;
  localparam int PW    = $clog2(NPHYS);
  localparam int NPORT = 3;  // A, B, write

  logic [CW-1:0]     cwp;
  logic [LREG_W-1:0] lreg [NPORT];
  logic [PW-1:0]     phys [NPORT];

  assign lreg[0] = ra_addr_i;
  assign lreg[1] = rb_addr_i;
  assign lreg[2] = wa_addr_i;

  win_ptr_ctrl #(.NWIN(NWIN), .CW(CW)) u_ptr (
    .clk_i, .rst_ni, .save_i, .restore_i, .wim_we_i, .wim_i,
    .cwp_o(cwp), .ovf_o, .unf_o
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    win_addr_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
      .cwp_i(cwp), .lreg_i(lreg[p]), .phys_o(phys[p])
    );
  end

  rf_storage #(.DW(DW), .NPHYS(NPHYS), .PW(PW)) u_store (
    .clk_i, .rst_ni,
    .ra_idx_i(phys[0]), .ra_data_o,
    .rb_idx_i(phys[1]), .rb_data_o,
    .we_i, .wa_idx_i(phys[2]), .wd_i
  );

  assign cwp_o = cwp;

  p_same_reg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_addr_i == rb_addr_i) |-> (ra_data_o == rb_data_o));

  p_g0_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_addr_i == '0) |-> (ra_data_o == '0));
endmodule

// File: tb/win_regfile_tb.sv
module win_regfile_tb;
  localparam int N  = 4;
  localparam int CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic save = 0, rest = 0, wim_we = 0;
  logic [N-1:0] wim = '0;
  logic [4:0] ra = '0, rb = '0, wa = '0;
  logic we = 0;
  logic [31:0] wd = '0;
  logic [31:0] rda, rdb;
  logic [CW-1:0] cwp;
  logic ovf, unf;
  int vecs = 0, errs = 0;
  int mcwp = 0;
  bit done = 0;

  always #2 clk = ~clk;

  win_regfile #(.NWIN(N), .DW(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .save_i(save), .restore_i(rest),
    .wim_we_i(wim_we), .wim_i(wim), .ra_addr_i(ra), .ra_data_o(rda),
    .rb_addr_i(rb), .rb_data_o(rdb), .we_i(we), .wa_addr_i(wa), .wd_i(wd),
    .cwp_o(cwp), .ovf_o(ovf), .unf_o(unf)
  );

  function automatic logic [31:0] vw(int w, int r);
    return 32'h5A00_0000 | (w << 8) | r;
  endfunction
  function automatic logic [31:0] vg(int r);
    return (r == 0) ? 32'h0 : (32'h6B00_0000 | r);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); we = 1; wa = a; wd = d;
    @(posedge clk); #1; we = 0;
  endtask

  task automatic rd2(string req, logic [4:0] a, logic [31:0] exp);
    ra = a; rb = a; #1;
    chk(req, rda, exp);
    chk(req, rdb, exp);
  endtask

  // one rotation cycle, then check pointer and flags, then that flags dropped
  task automatic rot(string req, bit s, bit r, int exp_cwp, bit eo, bit eu);
    @(negedge clk); save = s; rest = r;
    @(posedge clk); #1; save = 0; rest = 0;
    chk(req, 32'(cwp), 32'(exp_cwp));
    chk(req, 32'(ovf), 32'(eo));
    chk(req, 32'(unf), 32'(eu));
    mcwp = exp_cwp;
    @(posedge clk); #1;
    chk(req, {ovf, unf}, 32'h0);
  endtask

  task automatic load_wim(logic [N-1:0] m);
    @(negedge clk); wim_we = 1; wim = m;
    @(posedge clk); #1; wim_we = 0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R10: reset state
    chk("R10 cwp", 32'(cwp), 0);
    chk("R10 flags", {ovf, unf}, 0);
    // R7/R10: save target 3 masked at reset
    rot("R7 R10 save into masked", 1, 0, 0, 1, 0);
    // R6 then R8 at set 3
    rot("R6 restore", 0, 1, 1, 0, 0);
    rot("R6 restore", 0, 1, 2, 0, 0);
    rot("R8 restore into masked", 0, 1, 2, 0, 1);
    rot("R5 save", 1, 0, 1, 0, 0);
    rot("R5 save", 1, 0, 0, 0, 0);
    // R11: clear mask; wrap both ways
    load_wim('0);
    chk("R11 no move", 32'(cwp), 0);
    rot("R5 wrap", 1, 0, N - 1, 0, 0);
    rot("R6 wrap", 0, 1, 0, 0, 0);
    // fill globals and each set's ins/locals
    for (int g = 0; g < 8; g++) wr(5'(g), 32'h6B00_0000 | g);
    for (int s = 0; s < N; s++) begin
      for (int r = 16; r < 32; r++) wr(5'(r), vw(mcwp, r));
      rot("R6 sweep", 0, 1, (mcwp + 1) % N, 0, 0);
    end
    // R1 R2 R3 R4: read every logical register of every window
    for (int s = 0; s < N; s++) begin
      for (int r = 0; r < 32; r++) begin
        logic [31:0] e;
        if (r < 8) e = vg(r);
        else if (r < 16) e = vw((mcwp + N - 1) % N, r + 16);
        else e = vw(mcwp, r);
        rd2((r < 8) ? "R1 global" : (r < 16) ? "R4 outs" : "R3 window", 5'(r), e);
      end
      rot("R6 sweep", 0, 1, (mcwp + 1) % N, 0, 0);
    end
    // R4: write an out, find it as an in after save
    wr(5'd9, 32'hC0DE_0009);
    rot("R5 save", 1, 0, (mcwp + N - 1) % N, 0, 0);
    rd2("R4 out->in", 5'd25, 32'hC0DE_0009);
    rd2("R3 local private", 5'd17, vw(mcwp, 17));
    // R2: write to global 0 ignored
    wr(5'd0, 32'hFFFF_FFFF);
    rd2("R2 g0", 5'd0, 32'h0);
    rd2("R1 g1 intact", 5'd1, vg(1));
    // R9: same-cycle read returns old, new after edge
    @(negedge clk); we = 1; wa = 5'd18; wd = 32'hBEEF_0018; ra = 5'd18; rb = 5'd18;
    #1; chk("R9 old", rda, vw(mcwp, 18)); chk("R9 old", rdb, vw(mcwp, 18));
    @(posedge clk); #1; we = 0;
    chk("R9 new", rda, 32'hBEEF_0018);
    // R11: mask load and save together use old mask
    while (mcwp != 0) rot("R6 align", 0, 1, (mcwp + 1) % N, 0, 0);
    @(negedge clk); wim_we = 1; wim = 4'b1000; save = 1;
    @(posedge clk); #1; wim_we = 0; save = 0;
    chk("R11 old mask", 32'(cwp), 3);
    chk("R11 old mask", {ovf, unf}, 0);
    mcwp = 3;
    rot("R5 save", 1, 0, 2, 0, 0);
    rot("R11 R8 new mask", 0, 1, 2, 0, 1);
    // R12: save priority
    rot("R12 both save ok", 1, 1, 1, 0, 0);
    load_wim(4'b0001);
    rot("R12 both save blocked", 1, 1, 1, 1, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule